// File: doc/BRIEF.md
# Single-Bit AND Execution Unit

This unit carries out one instruction of a small 8-bit register-based controller. The instruction ANDs one chosen bit of one register with bit 0 of another, and writes the resulting bit back into a single bit position of the destination. The instruction arrives as three bytes on the unit's inputs together with a start strobe: an opcode byte, an operand byte, and a full register address. The operand byte holds a 4-bit working-register index, a 3-bit bit selector and a direction flag. The working-register index is widened into a register-file address by putting the working-bank base in front of it.

The unit reads both operands through a synchronous register-file port with one-cycle read latency. It merges the result bit into the destination byte and writes that byte back with a single write. In the same cycle it presents an updated status byte with a write strobe. Every accepted instruction takes a fixed number of cycles and ends with a one-cycle done pulse. A start that arrives with the wrong opcode is flagged as illegal and has no other effect.

Top module: `bitand_exec_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, done, illegal, rf_rd_en, rf_wr_en and flag_we are all 0.
- R2: The instruction is accepted when start is high, busy is low and op_byte equals 67h. In arg_byte, bit 0 is the direction, bits 3:1 are the bit selector b and bits 7:4 are the working index. The working register sits at address {bank_base, working index}. The other operand sits at address reg_byte.
- R3: With direction 0, the working register is rewritten with bit 0 replaced by (working bit 0 AND other-register bit b).
- R4: With direction 1, the register at reg_byte is rewritten with bit b replaced by (its own bit b AND working bit 0).
- R5: An instruction performs exactly one register write, to the destination. All bits other than the target bit keep their value, and no other register changes.
- R6: Flag bit 6 (zero) of flag_out is 1 when the result bit is 0, and 0 otherwise.
- R7: Flag bit 5 (sign) of flag_out is cleared. Bits 7 (carry), 3 (decimal adjust), 2 (half carry), 1 and 0 equal flag_in as sampled in the accepting cycle. Bit 4 (overflow) keeps its sampled value but is not specified.
- R8: done is high for exactly one cycle, in the cycle after the fifth rising edge counted from the edge that samples start (the sixth cycle counting the start cycle). rf_wr_en and flag_we are high in that same cycle.
- R9: A start that arrives while busy is high is ignored. The running instruction completes unchanged and only one done pulse appears.
- R10: A start with op_byte other than 67h while idle raises illegal for exactly the next cycle. It causes no read, no write, no flag_we and no done.
- R11: Each instruction issues two reads, at most one per cycle, and both come before the write. Read data is taken one cycle after rf_rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction with the bytes presented this cycle |
| op_byte | input | 8 | Opcode byte |
| arg_byte | input | 8 | Operand byte: working index, bit selector, direction |
| reg_byte | input | ADDR_W | Full address of the other register |
| bank_base | input | ADDR_W-4 | Upper address bits of the working bank |
| flag_in | input | 8 | Current status byte |
| rf_rd_data | input | 8 | Read data, valid one cycle after rf_rd_en |
| busy | output | 1 | An accepted instruction is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse after a start with a wrong opcode |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rd_addr | output | ADDR_W | Register-file read address |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_addr | output | ADDR_W | Register-file write address |
| rf_wr_data | output | 8 | Byte to write |
| flag_we | output | 1 | Status byte update strobe |
| flag_out | output | 8 | Updated status byte |

## Verification
The bench drives start just after a falling edge. The next falling edge follows the sampling rising edge, and there illegal is due for a wrong opcode. For a legal opcode, done is due exactly four falling edges later, and the bench counts those edges rather than waiting open-endedly. The register array and the captured status byte are compared one falling edge after done, once the write edge has passed. Read, write, done and flag-update counts are taken over the whole instruction, so that an extra or early access is caught even when the final contents look right.

// File: rtl/bitand_pkg.sv
package bitand_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned BIDX_W = $clog2(DATA_W);
    localparam int unsigned WIDX_W = 4;
    localparam int unsigned FLAG_W = 8;

    localparam logic [DATA_W-1:0] OPC_BAND = 8'h67;

    localparam int unsigned FLG_C = 7;
    localparam int unsigned FLG_Z = 6;
    localparam int unsigned FLG_S = 5;
    localparam int unsigned FLG_V = 4;
    localparam int unsigned FLG_D = 3;
    localparam int unsigned FLG_H = 2;

    // bits that must pass through unchanged (overflow excluded: unspecified)
    localparam logic [FLAG_W-1:0] FLG_KEEP_MASK =
        ~((FLAG_W'(1) << FLG_Z) | (FLAG_W'(1) << FLG_S) | (FLAG_W'(1) << FLG_V));

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RDW,
        PH_RDS,
        PH_CAPS,
        PH_EVAL,
        PH_WB
    } phase_e;

    typedef struct packed {
        logic              legal;
        logic [WIDX_W-1:0] widx;
        logic [BIDX_W-1:0] bsel;
        logic              dir;
    } decode_t;

    function automatic logic [FLAG_W-1:0] band_flags(input logic [FLAG_W-1:0] old,
                                                     input logic res);
        logic [FLAG_W-1:0] f;
        f        = old;
        f[FLG_Z] = ~res;
        f[FLG_S] = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/bitand_decode.sv
module bitand_decode
    import bitand_pkg::*;
#(
    parameter logic [DATA_W-1:0] OPCODE = OPC_BAND
) (
    input  logic [DATA_W-1:0] op_byte,
    input  logic [DATA_W-1:0] arg_byte,
    output decode_t           dec
);
    always_comb begin
        dec.legal = (op_byte == OPCODE);
        dec.widx  = arg_byte[DATA_W-1 -: WIDX_W];
        dec.bsel  = arg_byte[BIDX_W:1];
        dec.dir   = arg_byte[0];
    end
endmodule

// File: rtl/bitand_seq.sv
module bitand_seq
    import bitand_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   legal,
    output phase_e phase,
    output logic   accept,
    output logic   illegal
);
    assign accept = start && (phase == PH_IDLE) && legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            illegal <= 1'b0;
        end else begin
            illegal <= start && (phase == PH_IDLE) && !legal;
            unique case (phase)
                PH_IDLE: if (accept) phase <= PH_RDW;
                PH_RDW:  phase <= PH_RDS;
                PH_RDS:  phase <= PH_CAPS;
                PH_CAPS: phase <= PH_EVAL;
                PH_EVAL: phase <= PH_WB;
                PH_WB:   phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bitand_bitmerge.sv
module bitand_bitmerge #(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     din,
    input  logic [IDX_W-1:0] pos,
    input  logic             bit_in,
    output logic [W-1:0]     dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = (pos == IDX_W'(i)) ? bit_in : din[i];
    end
endmodule

// File: rtl/bitand_exec_unit.sv
module bitand_exec_unit
    import bitand_pkg::*;
#(
    parameter int unsigned       ADDR_W = 8,
    parameter logic [DATA_W-1:0] OPCODE = OPC_BAND
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [DATA_W-1:0]          op_byte,
    input  logic [DATA_W-1:0]          arg_byte,
    input  logic [ADDR_W-1:0]          reg_byte,
    input  logic [ADDR_W-WIDX_W-1:0]   bank_base,
    input  logic [FLAG_W-1:0]          flag_in,
    input  logic [DATA_W-1:0]          rf_rd_data,
    output logic                       busy,
    output logic                       done,
    output logic                       illegal,
    output logic                       rf_rd_en,
    output logic [ADDR_W-1:0]          rf_rd_addr,
    output logic                       rf_wr_en,
    output logic [ADDR_W-1:0]          rf_wr_addr,
    output logic [DATA_W-1:0]          rf_wr_data,
    output logic                       flag_we,
    output logic [FLAG_W-1:0]          flag_out
);
    decode_t dec;
    phase_e  phase;
    logic    accept;

    logic [ADDR_W-1:0] waddr_q, saddr_q, wb_addr_q;
    logic [BIDX_W-1:0] bsel_q;
    logic              dir_q;
    logic [FLAG_W-1:0] flags_q, flag_res_q;
    logic [DATA_W-1:0] wval_q, sval_q, wb_data_q;

    logic              res_bit;
    logic [DATA_W-1:0] merge_src, merged;
    logic [BIDX_W-1:0] merge_pos;

    bitand_decode #(.OPCODE(OPCODE)) u_dec (
        .op_byte (op_byte),
        .arg_byte(arg_byte),
        .dec     (dec)
    );

    bitand_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .legal  (dec.legal),
        .phase  (phase),
        .accept (accept),
        .illegal(illegal)
    );

    // evaluation: result bit is the same in both directions, only placement differs
    assign res_bit   = wval_q[0] & sval_q[bsel_q];
    assign merge_src = dir_q ? sval_q : wval_q;
    assign merge_pos = dir_q ? bsel_q : '0;

    bitand_bitmerge #(.W(DATA_W), .IDX_W(BIDX_W)) u_merge (
        .din   (merge_src),
        .pos   (merge_pos),
        .bit_in(res_bit),
        .dout  (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr_q    <= '0;
            saddr_q    <= '0;
            bsel_q     <= '0;
            dir_q      <= 1'b0;
            flags_q    <= '0;
            wval_q     <= '0;
            sval_q     <= '0;
            wb_addr_q  <= '0;
            wb_data_q  <= '0;
            flag_res_q <= '0;
        end else begin
            if (accept) begin
                waddr_q <= {bank_base, dec.widx};
                saddr_q <= reg_byte;
                bsel_q  <= dec.bsel;
                dir_q   <= dec.dir;
                flags_q <= flag_in;
            end
            if (phase == PH_RDS)  wval_q <= rf_rd_data;
            if (phase == PH_CAPS) sval_q <= rf_rd_data;
            if (phase == PH_EVAL) begin
                wb_data_q  <= merged;
                wb_addr_q  <= dir_q ? saddr_q : waddr_q;
                flag_res_q <= band_flags(flags_q, res_bit);
            end
        end
    end

    assign busy       = (phase != PH_IDLE);
    assign rf_rd_en   = (phase == PH_RDW) || (phase == PH_RDS);
    assign rf_rd_addr = (phase == PH_RDS) ? saddr_q : waddr_q;
    assign rf_wr_en   = (phase == PH_WB);
    assign rf_wr_addr = wb_addr_q;
    assign rf_wr_data = wb_data_q;
    assign done       = (phase == PH_WB);
    assign flag_we    = (phase == PH_WB);
    assign flag_out   = flag_res_q;

endmodule

// File: rtl/bitand_exec_unit_chk.sv
module bitand_exec_unit_chk
    import bitand_pkg::*;
#(
    parameter logic [DATA_W-1:0] OPCODE = OPC_BAND
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [DATA_W-1:0] op_byte,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic              rf_rd_en,
    input logic              rf_wr_en,
    input logic              flag_we,
    input logic [FLAG_W-1:0] flag_in,
    input logic [FLAG_W-1:0] flag_out
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_latency_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start && !busy && (op_byte == OPCODE), 5));

    assert_reads_before_write_R11: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> ($past(rf_rd_en, 4) && $past(rf_rd_en, 3)));

    assert_no_rd_wr_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(rf_rd_en && rf_wr_en));

    assert_sign_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> !flag_out[FLG_S]);

    assert_flags_kept_R7: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> ((flag_out & FLG_KEEP_MASK) == ($past(flag_in, 5) & FLG_KEEP_MASK)));

    assert_illegal_cause_R10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> ($past(start && !busy && (op_byte != OPCODE)) && !busy));

    assert_illegal_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        illegal |=> !illegal);
endmodule

bind bitand_exec_unit bitand_exec_unit_chk #(.OPCODE(OPCODE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_byte (op_byte),
    .busy    (busy),
    .done    (done),
    .illegal (illegal),
    .rf_rd_en(rf_rd_en),
    .rf_wr_en(rf_wr_en),
    .flag_we (flag_we),
    .flag_in (flag_in),
    .flag_out(flag_out)
);

// File: tb/bitand_exec_unit_test.sv
`timescale 1ns/1ps
module bitand_exec_unit_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] op_byte = 8'h00, arg_byte = 8'h00, reg_byte = 8'h00;
    logic [3:0] bank_base = 4'h0;
    logic [7:0] flag_in = 8'h00;
    logic [7:0] rf_rd_data;
    logic       busy, done, illegal, rf_rd_en, rf_wr_en, flag_we;
    logic [7:0] rf_rd_addr, rf_wr_addr, rf_wr_data, flag_out;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    logic [7:0] mem [256];
    logic       poke_en = 1'b0;
    logic [7:0] poke_addr = 8'h00, poke_val = 8'h00;
    logic [7:0] flag_seen;
    int rd_cnt = 0, wr_cnt = 0, dn_cnt = 0, fw_cnt = 0, bad_order = 0, rd_since_wr = 0;

    always #2 clk = ~clk;

    bitand_exec_unit uut (
        .clk(clk), .rst(rst), .start(start), .op_byte(op_byte), .arg_byte(arg_byte),
        .reg_byte(reg_byte), .bank_base(bank_base), .flag_in(flag_in),
        .rf_rd_data(rf_rd_data), .busy(busy), .done(done), .illegal(illegal),
        .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_wr_en(rf_wr_en),
        .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data), .flag_we(flag_we),
        .flag_out(flag_out)
    );

    // register-file and flag model
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 29 + 7);
            rf_rd_data <= 8'h00;
            flag_seen  <= 8'h00;
        end else begin
            if (poke_en) mem[poke_addr] <= poke_val;
            if (rf_rd_en) begin
                rf_rd_data  <= mem[rf_rd_addr];
                rd_cnt      <= rd_cnt + 1;
                rd_since_wr <= rd_since_wr + 1;
            end
            if (rf_wr_en) begin
                mem[rf_wr_addr] <= rf_wr_data;
                wr_cnt          <= wr_cnt + 1;
                if (rd_since_wr < 2) bad_order <= bad_order + 1;
                rd_since_wr     <= 0;
            end
            if (done) dn_cnt <= dn_cnt + 1;
            if (flag_we) begin
                flag_seen <= flag_out;
                fw_cnt    <= fw_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_flags(input logic [7:0] f, input logic res);
        logic [7:0] r;
        r    = f;
        r[6] = ~res;
        r[5] = 1'b0;
        return r;
    endfunction

    task automatic poke(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_val = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic run_instr(input logic [7:0] opc, input logic [7:0] arg,
                             input logic [7:0] addr, input logic [3:0] bank,
                             input logic [7:0] fl, input bit inject);
        logic [7:0] snap [256];
        logic [7:0] waddr, w, s, tgt_addr, tgt_exp, fexp;
        logic       res;
        int k, rd0, wr0, dn0, fw0, bad0, diffs;
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
        waddr = {bank, arg[7:4]};
        w     = snap[waddr];
        s     = snap[addr];
        res   = w[0] & s[arg[3:1]];
        fexp  = model_flags(fl, res);
        if (arg[0] == 1'b0) begin
            tgt_addr = waddr;
            tgt_exp  = {w[7:1], res};
        end else begin
            tgt_addr = addr;
            tgt_exp  = s;
            tgt_exp[arg[3:1]] = res;
        end
        rd0 = rd_cnt; wr0 = wr_cnt; dn0 = dn_cnt; fw0 = fw_cnt; bad0 = bad_order;

        @(negedge clk);
        start = 1'b1; op_byte = opc; arg_byte = arg; reg_byte = addr;
        bank_base = bank; flag_in = fl;
        @(negedge clk);
        start = 1'b0;

        if (opc != 8'h67) begin
            check(illegal == 1'b1, "R10 illegal pulse", int'(illegal), 1);
            @(negedge clk);
            check(illegal == 1'b0, "R10 illegal one cycle", int'(illegal), 0);
            repeat (7) @(negedge clk);
            check(rd_cnt == rd0 && wr_cnt == wr0 && dn_cnt == dn0 && fw_cnt == fw0,
                  "R10 no access", rd_cnt + wr_cnt + dn_cnt + fw_cnt, rd0 + wr0 + dn0 + fw0);
            diffs = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== snap[i]) diffs++;
            check(diffs == 0, "R10 registers untouched", diffs, 0);
            return;
        end

        check(illegal == 1'b0, "R10 no illegal on legal opcode", int'(illegal), 0);
        k = 0;
        while (!done && k < 12) begin
            @(negedge clk);
            k++;
            if (inject && k == 1) begin
                start = 1'b1; op_byte = 8'h67; arg_byte = ~arg; reg_byte = ~addr;
                bank_base = ~bank; flag_in = ~fl;
            end
            if (inject && k == 2) start = 1'b0;
        end
        check(k == 4, "R8 done latency", k, 4);
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", int'(done), 0);
        check(mem[tgt_addr] === tgt_exp, arg[0] ? "R2 R4 destination byte" : "R2 R3 destination byte",
              int'(mem[tgt_addr]), int'(tgt_exp));
        diffs = 0;
        for (int i = 0; i < 256; i++)
            if (i != int'(tgt_addr) && mem[i] !== snap[i]) diffs++;
        check(diffs == 0, "R5 other registers unchanged", diffs, 0);
        check(flag_seen[6] == ~res, "R6 zero flag", int'(flag_seen[6]), int'(~res));
        check((flag_seen & 8'hEF) == (fexp & 8'hEF), "R7 other flags", int'(flag_seen & 8'hEF),
              int'(fexp & 8'hEF));
        check(rd_cnt - rd0 == 2 && wr_cnt - wr0 == 1 && bad_order == bad0, "R11 access order",
              (rd_cnt - rd0) * 16 + (wr_cnt - wr0), 2 * 16 + 1);
        repeat (3) @(negedge clk);
        check(dn_cnt - dn0 == 1 && fw_cnt - fw0 == 1, inject ? "R9 busy start ignored" : "R8 one done",
              dn_cnt - dn0, 1);
    endtask

    initial begin
        logic [7:0] opc;
        int seed_val;
        seed_val = $urandom(32'd7103);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !illegal && !rf_rd_en && !rf_wr_en && !flag_we, "R1 reset state",
              {26'd0, busy, done, illegal, rf_rd_en, rf_wr_en, flag_we}, 0);

        // worked example: bank C, index 1 -> C1h = 07h, other 01h = 05h, b=1, direction 0
        poke(8'hC1, 8'h07);
        poke(8'h01, 8'h05);
        run_instr(8'h67, 8'h12, 8'h01, 4'hC, 8'h00, 1'b0);
        check(mem[8'hC1] == 8'h06 && mem[8'h01] == 8'h05 && flag_seen[6], "R3 worked example",
              int'(mem[8'hC1]), 8'h06);
        // direction 1, top bit, result 1
        poke(8'h30, 8'h80);
        poke(8'h25, 8'h01);
        run_instr(8'h67, 8'h5F, 8'h30, 4'h2, 8'hFF, 1'b0);
        // direction 1, bit 0, working bit 0 clear
        poke(8'h40, 8'hFF);
        poke(8'h2A, 8'hFE);
        run_instr(8'h67, 8'hA1, 8'h40, 4'h2, 8'hA5, 1'b0);
        // both operands in the same register
        poke(8'h33, 8'h03);
        run_instr(8'h67, 8'h32, 8'h33, 4'h3, 8'h5A, 1'b0);
        poke(8'h33, 8'h02);
        run_instr(8'h67, 8'h33, 8'h33, 4'h3, 8'h00, 1'b0);
        // wrong opcode, and a start while busy
        run_instr(8'h66, 8'h12, 8'h01, 4'hC, 8'h3C, 1'b0);
        run_instr(8'h67, 8'h7B, 8'h10, 4'h9, 8'hC3, 1'b1);

        for (int n = 0; n < 80; n++) begin
            opc = 8'h67;
            if ($urandom % 8 == 0) begin
                opc = 8'($urandom);
                if (opc == 8'h67) opc = 8'h68;
            end
            run_instr(opc, 8'($urandom), 8'($urandom), 4'($urandom), 8'($urandom),
                      ($urandom % 4) == 0);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule